// File: doc/BRIEF.md
# DRAM Controller Operating-State Sequencer

This block holds the operating mode of a DRAM protocol controller. Software asks for a mode change by writing a 3-bit command code. The block then moves through the legal path toward the requested mode. Its current position is always readable as a 3-bit status code.

The controller has four resting modes: init, config, access and low-power. Every move between them passes through a transient request state. That state is held for a dwell count given with the command. Moves into and out of low-power also wait for an acknowledge from the memory side. Commands that are not legal in the present mode are dropped. Commands that arrive while a request state is still in progress are dropped as well.

Some moves need several steps. Reaching config from low-power takes a wakeup to access first, then a config command. Reaching access from init takes config first, then go. Software is expected to issue these steps in order.

Top module: `osf_opstate_fsm`

## Requirements
- R1: After reset, `stat` reads 0 (init), and both `lp_entry_req` and `lp_exit_req` are low. The status codes are: 0 init, 1 config, 2 config-request, 3 access, 4 access-request, 5 low-power, 6 low-power-entry-request, 7 low-power-exit-request.
- R2: A config command (code 1) accepted in init (0) or access (3) moves `stat` to 2 (config-request) and then to 1 (config).
- R3: A go command (code 2) accepted in config (1) moves `stat` to 4 (access-request) and then to 3 (access).
- R4: A sleep command (code 3) accepted in access moves `stat` to 6 (low-power-entry-request) and then to 5 (low-power). `lp_entry_req` is high exactly while `stat` is 6. The move to 5 waits until `lp_entry_ack` is high.
- R5: A wakeup command (code 4) accepted in low-power moves `stat` to 7 (low-power-exit-request) and then to 3 (access), never to config. `lp_exit_req` is high exactly while `stat` is 7. The move to 3 waits until `lp_exit_ack` is high.
- R6: `dwell_cycles` is sampled when a command is accepted. The request state is then reported for max(`dwell_cycles`,1) cycles, plus any cycles spent waiting for an acknowledge.
- R7: A command that is not legal in the present resting state leaves `stat` unchanged. This covers config from low-power, go outside config, sleep outside access, wakeup outside low-power, config from config, code 0 (init) in any state, and the unused codes 5 to 7.
- R8: A command presented while `stat` is a request state (2, 4, 6 or 7) is ignored. It does not shorten or redirect the move in progress.
- R9: While `cmd_valid` is low, a resting state is held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_code | input | 3 | Command: 0 init, 1 config, 2 go, 3 sleep, 4 wakeup |
| dwell_cycles | input | DWELL_W | Request-state dwell, sampled when the command is accepted |
| lp_entry_ack | input | 1 | Memory side agrees to enter low-power |
| lp_exit_ack | input | 1 | Memory side agrees to leave low-power |
| stat | output | 3 | Current operating status code |
| lp_entry_req | output | 1 | Low-power entry request toward the memory side |
| lp_exit_req | output | 1 | Low-power exit request toward the memory side |

## Verification
The assertions check on every cycle that each resting state is entered only from its own request state, and that low-power is entered or left only after the matching acknowledge. They also check that the two handshake requests are never high together. On every cycle they further check that refused commands, idle cycles and commands during an unfinished dwell leave the status unchanged. Only the bench's scenarios can show that complete multi-step paths land on the right mode, such as init to access through config, or low-power back to access. The same holds for dwell lengths, including a dwell of zero, and for the extra cycles added by a late acknowledge.

// File: rtl/osf_pkg.sv
package osf_pkg;

  typedef enum logic [2:0] {
    ST_INIT    = 3'd0,
    ST_CONFIG  = 3'd1,
    ST_CFG_REQ = 3'd2,
    ST_ACCESS  = 3'd3,
    ST_ACC_REQ = 3'd4,
    ST_LOWPWR  = 3'd5,
    ST_LPE_REQ = 3'd6,
    ST_LPX_REQ = 3'd7
  } osf_state_e;

  localparam logic [2:0] OP_INIT   = 3'd0;
  localparam logic [2:0] OP_CONFIG = 3'd1;
  localparam logic [2:0] OP_GO     = 3'd2;
  localparam logic [2:0] OP_SLEEP  = 3'd3;
  localparam logic [2:0] OP_WAKEUP = 3'd4;

  function automatic logic is_resting(input osf_state_e s);
    return (s == ST_INIT) || (s == ST_CONFIG) || (s == ST_ACCESS) || (s == ST_LOWPWR);
  endfunction

  // Request state entered for a command in a resting state; returns the
  // current state when the command is not legal there.
  function automatic osf_state_e route_cmd(input osf_state_e cur, input logic [2:0] op);
    osf_state_e nxt;
    nxt = cur;
    unique case (cur)
      ST_INIT:   if (op == OP_CONFIG) nxt = ST_CFG_REQ;
      ST_CONFIG: if (op == OP_GO)     nxt = ST_ACC_REQ;
      ST_ACCESS: begin
        if (op == OP_CONFIG)     nxt = ST_CFG_REQ;
        else if (op == OP_SLEEP) nxt = ST_LPE_REQ;
      end
      ST_LOWPWR: if (op == OP_WAKEUP) nxt = ST_LPX_REQ;
      default:   nxt = cur;
    endcase
    return nxt;
  endfunction

  // Resting state that a request state settles into.
  function automatic osf_state_e settle_of(input osf_state_e req);
    osf_state_e tgt;
    unique case (req)
      ST_CFG_REQ: tgt = ST_CONFIG;
      ST_ACC_REQ: tgt = ST_ACCESS;
      ST_LPE_REQ: tgt = ST_LOWPWR;
      ST_LPX_REQ: tgt = ST_ACCESS;
      default:    tgt = req;
    endcase
    return tgt;
  endfunction

  // Dwell load value: a request of zero still shows for one cycle.
  function automatic logic [7:0] dwell_load(input logic [7:0] req_cycles);
    return (req_cycles == 8'd0) ? 8'd0 : req_cycles - 8'd1;
  endfunction

endpackage

// File: rtl/osf_cmd_decode.sv
module osf_cmd_decode
  import osf_pkg::*;
(
  input  osf_state_e cur_state,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_code,
  output logic       cmd_accept,
  output osf_state_e req_state
);

  osf_state_e routed;

  always_comb begin
    routed     = route_cmd(cur_state, cmd_code);
    cmd_accept = cmd_valid && is_resting(cur_state) && (routed != cur_state);
    req_state  = routed;
  end

endmodule

// File: rtl/osf_dwell_timer.sv
module osf_dwell_timer
  import osf_pkg::*;
#(
  parameter int DWELL_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [DWELL_W-1:0] dwell,
  output logic               done
);

  logic [DWELL_W-1:0] cnt;
  logic [7:0]         wide_req;
  logic [7:0]         wide_load;

  always_comb begin
    wide_req  = 8'(dwell);
    wide_load = dwell_load(wide_req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= wide_load[DWELL_W-1:0];
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/osf_opstate_fsm.sv
module osf_opstate_fsm
  import osf_pkg::*;
#(
  parameter int DWELL_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [2:0]         cmd_code,
  input  logic [DWELL_W-1:0] dwell_cycles,
  input  logic               lp_entry_ack,
  input  logic               lp_exit_ack,
  output logic [2:0]         stat,
  output logic               lp_entry_req,
  output logic               lp_exit_req
);

  osf_state_e state;
  osf_state_e req_state;
  logic       cmd_accept;
  logic       dwell_done;
  logic       hs_ok;
  logic       settle;

  osf_cmd_decode u_dec (
    .cur_state  (state),
    .cmd_valid  (cmd_valid),
    .cmd_code   (cmd_code),
    .cmd_accept (cmd_accept),
    .req_state  (req_state)
  );

  osf_dwell_timer #(.DWELL_W(DWELL_W)) u_dwell (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cmd_accept),
    .dwell (dwell_cycles),
    .done  (dwell_done)
  );

  always_comb begin
    unique case (state)
      ST_LPE_REQ: hs_ok = lp_entry_ack;
      ST_LPX_REQ: hs_ok = lp_exit_ack;
      default:    hs_ok = 1'b1;
    endcase
    settle = !is_resting(state) && dwell_done && hs_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_INIT;
    end else if (cmd_accept) begin
      state <= req_state;
    end else if (settle) begin
      state <= settle_of(state);
    end
  end

  assign stat         = state;
  assign lp_entry_req = (state == ST_LPE_REQ);
  assign lp_exit_req  = (state == ST_LPX_REQ);

endmodule

// File: rtl/osf_opstate_chk.sv
module osf_opstate_chk
  import osf_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       lp_entry_ack,
  input logic       lp_exit_ack,
  input logic [2:0] stat,
  input logic       lp_entry_req,
  input logic       lp_exit_req,
  input logic       cmd_accept,
  input logic       dwell_done
);

  logic resting;
  assign resting = (stat == ST_INIT) || (stat == ST_CONFIG) ||
                   (stat == ST_ACCESS) || (stat == ST_LOWPWR);

  AST_CONFIG_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat == ST_CONFIG && $past(stat) != ST_CONFIG) |-> $past(stat) == ST_CFG_REQ); // R2

  AST_ACCESS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat == ST_ACCESS && $past(stat) != ST_ACCESS) |->
      ($past(stat) == ST_ACC_REQ || $past(stat) == ST_LPX_REQ)); // R3

  AST_LOWPWR_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat == ST_LOWPWR && $past(stat) != ST_LOWPWR) |->
      ($past(stat) == ST_LPE_REQ && $past(lp_entry_ack))); // R4

  AST_LOWPWR_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stat) == ST_LPX_REQ && stat != ST_LPX_REQ) |->
      (stat == ST_ACCESS && $past(lp_exit_ack))); // R5

  AST_HS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lp_entry_req, lp_exit_req})); // R4

  AST_DWELL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!resting && !dwell_done) |=> $stable(stat)); // R6

  AST_REFUSED_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (resting && cmd_valid && !cmd_accept) |=> $stable(stat)); // R7

  AST_REQ_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!resting) |-> !cmd_accept); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (resting && !cmd_valid) |=> $stable(stat)); // R9

endmodule

bind osf_opstate_fsm osf_opstate_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_valid    (cmd_valid),
  .lp_entry_ack (lp_entry_ack),
  .lp_exit_ack  (lp_exit_ack),
  .stat         (stat),
  .lp_entry_req (lp_entry_req),
  .lp_exit_req  (lp_exit_req),
  .cmd_accept   (cmd_accept),
  .dwell_done   (dwell_done)
);

// File: tb/sim_osf_opstate_fsm.sv
module sim_osf_opstate_fsm;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_code = 3'd0;
  logic [DW-1:0] dwell_cycles = '0;
  logic          lp_entry_ack = 1'b1;
  logic          lp_exit_ack = 1'b1;
  logic [2:0]    stat;
  logic          lp_entry_req;
  logic          lp_exit_req;

  int checks = 0;
  int errors = 0;
  logic [2:0] cur = 3'd0;
  logic [2:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  osf_opstate_fsm #(.DWELL_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .dwell_cycles(dwell_cycles), .lp_entry_ack(lp_entry_ack), .lp_exit_ack(lp_exit_ack),
    .stat(stat), .lp_entry_req(lp_entry_req), .lp_exit_req(lp_exit_req)
  );

  // Monitor: compare each result a quarter period after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (exp_q.size() > 0) begin
        logic [2:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (stat !== e || lp_entry_req !== (e == 3'd6) || lp_exit_req !== (e == 3'd7)) begin
          errors++;
          $display("FAIL %s: stat=%0d lpe=%0b lpx=%0b expected stat=%0d lpe=%0b lpx=%0b",
                   t, stat, lp_entry_req, lp_exit_req, e, (e == 3'd6), (e == 3'd7));
        end
      end
    end
  end

  task automatic idle(input int n, input string tag);
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(cur);
      tag_q.push_back(tag);
    end
    for (int j = 1; j <= n; j++) @(negedge clk);
  endtask

  // Driver: presents one command and queues the status sequence it implies.
  task automatic issue(input logic [2:0] code, input int dwell, input bit legal,
                       input logic [2:0] req, input logic [2:0] tgt,
                       input int ack_delay, input bit interfere, input string tag);
    int d;
    int n;
    d = (dwell == 0) ? 1 : dwell;
    @(negedge clk);
    cmd_valid    = 1'b1;
    cmd_code     = code;
    dwell_cycles = DW'(dwell);
    if (legal && ack_delay > 0) begin
      lp_entry_ack = 1'b0;
      lp_exit_ack  = 1'b0;
    end
    if (legal) begin
      for (int i = 0; i < d + ack_delay; i++) begin
        exp_q.push_back(req);
        tag_q.push_back(tag);
      end
      exp_q.push_back(tgt);
      tag_q.push_back(tag);
      n = d + ack_delay + 1;
      cur = tgt;
    end else begin
      exp_q.push_back(cur);
      tag_q.push_back(tag);
      exp_q.push_back(cur);
      tag_q.push_back(tag);
      n = 2;
    end
    for (int j = 1; j <= n; j++) begin
      @(negedge clk);
      if (j == 1) begin
        cmd_valid    = interfere;
        cmd_code     = 3'd1;
        dwell_cycles = '0;
      end
      if (j == 2) cmd_valid = 1'b0;
      if (ack_delay > 0 && j == d + ack_delay) begin
        lp_entry_ack = 1'b1;
        lp_exit_ack  = 1'b1;
      end
    end
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    checks++;
    if (stat !== 3'd0 || lp_entry_req !== 1'b0 || lp_exit_req !== 1'b0) begin
      errors++;
      $display("FAIL R1: stat=%0d lpe=%0b lpx=%0b expected 0 0 0", stat, lp_entry_req, lp_exit_req);
    end
    idle(3, "R9 idle in init");
    issue(3'd2, 2, 1'b0, 3'd0, 3'd0, 0, 1'b0, "R7 go from init");
    issue(3'd3, 2, 1'b0, 3'd0, 3'd0, 0, 1'b0, "R7 sleep from init");
    issue(3'd6, 2, 1'b0, 3'd0, 3'd0, 0, 1'b0, "R7 unused code");
    issue(3'd1, 3, 1'b1, 3'd2, 3'd1, 0, 1'b1, "R2 config from init, R8 cmd during dwell");
    issue(3'd1, 1, 1'b0, 3'd0, 3'd0, 0, 1'b0, "R7 config from config");
    issue(3'd0, 1, 1'b0, 3'd0, 3'd0, 0, 1'b0, "R7 init code");
    idle(2, "R9 idle in config");
    issue(3'd2, 0, 1'b1, 3'd4, 3'd3, 0, 1'b0, "R3 go dwell zero, R6");
    issue(3'd1, 1, 1'b1, 3'd2, 3'd1, 0, 1'b0, "R2 config from access");
    issue(3'd2, 2, 1'b1, 3'd4, 3'd3, 0, 1'b0, "R3 go dwell two, R6");
    issue(3'd4, 2, 1'b0, 3'd0, 3'd0, 0, 1'b0, "R7 wakeup from access");
    issue(3'd3, 2, 1'b1, 3'd6, 3'd5, 2, 1'b1, "R4 sleep late ack, R8");
    issue(3'd1, 2, 1'b0, 3'd0, 3'd0, 0, 1'b0, "R7 config from low-power");
    issue(3'd2, 2, 1'b0, 3'd0, 3'd0, 0, 1'b0, "R7 go from low-power");
    idle(2, "R9 idle in low-power");
    issue(3'd4, 1, 1'b1, 3'd7, 3'd3, 0, 1'b0, "R5 wakeup to access");
    issue(3'd3, 5, 1'b1, 3'd6, 3'd5, 0, 1'b0, "R4 sleep dwell five, R6");
    issue(3'd4, 2, 1'b1, 3'd7, 3'd3, 3, 1'b1, "R5 wakeup late ack, R8");
    issue(3'd1, 15, 1'b1, 3'd2, 3'd1, 0, 1'b0, "R6 max dwell");
    idle(2, "R9 final hold");
    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule